// File: doc/BRIEF.md
# Configurable Sync/Async Character Framer

This block sits between a byte-wide data path and a serial bit stream. It has a transmit framer, which turns bytes into bits, and a receive deframer, which turns bits back into bytes. An 8-bit mode word selects one of two framings:

- **Synchronous bypass.** Bytes travel as bare 8-bit groups with no framing.
- **Asynchronous.** Each character carries a low start bit, then 7 or 8 data bits, then an optional odd or even parity bit, then a programmable number of stop bits. Zero stop bits is allowed.

A one-cycle bit-rate strobe paces both directions. The transmitter updates its line output only on a strobe cycle. The receiver samples its line input only on a strobe cycle, and that input is assumed to be already bit-aligned by the surrounding logic.

Bytes enter through a valid/ready handshake backed by a single holding register:

- `tx_ready_o` is high while the holding register is empty.
- A byte is taken on any cycle where both valid and ready are high.
- The holding register empties when its contents are moved into the shifter at a character boundary. This leaves a full character time to supply the next byte.

Received characters leave through a valid/ready output:

- `rx_valid_o` stays high, and the data stays unchanged, until `rx_ready_i` is seen high.
- The serial line cannot be stalled. A character that completes while the previous one is still unaccepted replaces it.

The mode word is sampled only at character boundaries.

Top module: `char_framer`

## Requirements
- R1: With mode bit 5 at 0, the transmitter sends each byte as 8 bits, least significant bit first. Bytes follow one another with no extra bits while the holding register is kept full.
- R2: With mode bit 5 at 0, the receiver groups every 8 sampled bits into one byte, least significant bit first, counting from reset. It reports a parity error of 0.
- R3: With mode bit 5 at 1, each transmitted character is built as follows:
  - a start bit of 0;
  - the data bits, LSB first: 7 bits (bits 0-6) when mode bit 0 is 1, otherwise 8;
  - when mode bit 2 is 1, a parity bit whose sense is odd when mode bit 1 is 1 and even when it is 0;
  - stop bits of 1, counted from mode bits 4:3 as 00=0, 01=1, 10=1, 11=2.
- R4: In asynchronous mode, the receiver starts a character on a sampled 0 and collects the configured data bits. When parity is enabled it flags a mismatch against the configured sense. In 7-bit mode, bit 7 of the output byte is 0.
- R5: The receiver accepts a new start bit on the strobe immediately after the last data or parity bit, with no stop bit in between.
- R6: After reset the line output is 1 and `tx_ready_o` is 1. `tx_ready_o` falls once a byte is accepted and stays low until that byte is loaded. With nothing to send, the line idles at 1.
- R7: `rx_valid_o`, `rx_data_o` and `rx_perr_o` hold until `rx_ready_i` is seen high. A newly completed character overwrites an unaccepted one.
- R8: A mode change while a character is in progress does not alter that character in either direction. It applies from the next character.
- R9: Mode bits 7:6 have no effect.
- R10: The line output changes only on strobe cycles, and the receiver changes state only on strobe cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 8 | Mode word: [5] async, [4:3] stop code, [2] parity enable, [1] odd, [0] 7-bit |
| bit_tick_i | input | 1 | One-cycle bit-rate strobe |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_data_i | input | CHAR_W | Transmit byte |
| tx_ready_o | output | 1 | Holding register empty |
| tx_serial_o | output | 1 | Serial line out |
| rx_serial_i | input | 1 | Serial line in, bit-aligned |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Received byte accepted |
| rx_data_o | output | CHAR_W | Received byte |
| rx_perr_o | output | 1 | Parity mismatch for the byte on rx_data_o |

## Verification
The bench builds the block with its default CHAR_W of 8. This brings both data widths, every stop code, and both parity senses within reach of the mode word.

The transmit output is looped back into the receiver, so the zero-stop-bit codes produce back-to-back start bits at the receiver. This is how the no-gap start detection is exercised. The receiver is also driven directly, for synchronous grouping and for deliberate parity faults.

// File: rtl/framer_pkg.sv
package framer_pkg;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       async_en;
    logic [1:0] stop_code;
    logic       par_en;
    logic       par_odd;
    logic       short7;
  } mode_t;

  function automatic logic [1:0] stop_count(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b11:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/framer_tx.sv
module framer_tx
  import framer_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  mode_t             mode_i,
  input  logic              in_valid_i,
  input  logic [CHAR_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              serial_o
);
  localparam int FRAME_W = CHAR_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic              hold_full;
  logic [CHAR_W-1:0] hold_data;
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   rem;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   flen;
  logic               load;
  logic [CHAR_W-1:0]  dmask;
  logic               par_bit;

  assign in_ready_o = !hold_full;
  assign load       = tick_i && (rem == '0) && hold_full;
  assign dmask      = mode_i.short7 ? {1'b0, {(CHAR_W-1){1'b1}}} : {CHAR_W{1'b1}};
  assign par_bit    = (^(hold_data & dmask)) ^ mode_i.par_odd;

  // Frame assembly from the holding register and the mode seen at load
  always_comb begin
    int nd;
    int pos;
    frame = {FRAME_W{1'b1}};
    flen  = LEN_W'(CHAR_W);
    nd    = mode_i.short7 ? CHAR_W - 1 : CHAR_W;
    pos   = 0;
    if (!mode_i.async_en) begin
      frame[CHAR_W-1:0] = hold_data;
    end else begin
      frame[0] = 1'b0;
      for (int i = 0; i < CHAR_W; i++) begin
        if (i < nd) frame[1+i] = hold_data[i];
      end
      pos = 1 + nd;
      if (mode_i.par_en) begin
        frame[pos] = par_bit;
        pos = pos + 1;
      end
      flen = LEN_W'(pos + int'(stop_count(mode_i.stop_code)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (in_valid_i && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= in_data_i;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= {FRAME_W{1'b1}};
      rem      <= '0;
      serial_o <= 1'b1;
    end else if (tick_i) begin
      if (rem != '0) begin
        serial_o <= shreg[0];
        shreg    <= {1'b1, shreg[FRAME_W-1:1]};
        rem      <= rem - LEN_W'(1);
      end else if (hold_full) begin
        serial_o <= frame[0];
        shreg    <= {1'b1, frame[FRAME_W-1:1]};
        rem      <= flen - LEN_W'(1);
      end else begin
        serial_o <= 1'b1;
      end
    end
  end

  a_r10_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(serial_o));
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode_i.async_en) |=> !serial_o);
  a_r1_sync_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !mode_i.async_en) |=> (serial_o == $past(hold_data[0])));
  a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !load) |=> (hold_full && $stable(hold_data)));

endmodule

// File: rtl/framer_rx.sv
module framer_rx
  import framer_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  mode_t             mode_i,
  input  logic              serial_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [CHAR_W-1:0] out_data_o,
  output logic              out_perr_o
);
  localparam int IDX_W = $clog2(CHAR_W);

  typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_PAR} rx_state_t;

  rx_state_t         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_idx;
  logic [CHAR_W-1:0] data_q, data_d, e_data;
  logic              acc_q, acc_d, emit, e_perr;
  mode_t             cfg_q, cfg_d;

  assign last_idx = (cfg_q.async_en && cfg_q.short7) ? IDX_W'(CHAR_W - 2)
                                                     : IDX_W'(CHAR_W - 1);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    data_d = data_q;
    acc_d  = acc_q;
    cfg_d  = cfg_q;
    emit   = 1'b0;
    e_data = data_q;
    e_perr = 1'b0;
    if (tick_i) begin
      case (st_q)
        RX_IDLE: begin
          if (!mode_i.async_en) begin
            cfg_d     = mode_i;
            data_d    = '0;
            data_d[0] = serial_i;
            acc_d     = serial_i;
            idx_d     = IDX_W'(1);
            st_d      = RX_DATA;
          end else if (!serial_i) begin
            cfg_d  = mode_i;
            data_d = '0;
            acc_d  = 1'b0;
            idx_d  = '0;
            st_d   = RX_DATA;
          end
        end
        RX_DATA: begin
          data_d[idx_q] = serial_i;
          acc_d         = acc_q ^ serial_i;
          if (idx_q == last_idx) begin
            if (cfg_q.async_en && cfg_q.par_en) begin
              st_d = RX_PAR;
            end else begin
              emit   = 1'b1;
              e_data = data_d;
              st_d   = RX_IDLE;
            end
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
        RX_PAR: begin
          emit   = 1'b1;
          e_data = data_q;
          e_perr = serial_i != (acc_q ^ cfg_q.par_odd);
          st_d   = RX_IDLE;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      idx_q  <= '0;
      data_q <= '0;
      acc_q  <= 1'b0;
      cfg_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      data_q <= data_d;
      acc_q  <= acc_d;
      cfg_q  <= cfg_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_perr_o  <= 1'b0;
    end else if (emit) begin
      out_valid_o <= 1'b1;
      out_data_o  <= e_data;
      out_perr_o  <= e_perr;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  a_r7_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> out_valid_o);
  a_r4_short_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && cfg_q.async_en && cfg_q.short7) |=> (out_data_o[CHAR_W-1] == 1'b0));
  a_r4_perr_needs_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !(cfg_q.async_en && cfg_q.par_en)) |=> !out_perr_o);
  a_r10_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(st_q) && $stable(idx_q)));

endmodule

// File: rtl/char_framer.sv
module char_framer
  import framer_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        mode_i,
  input  logic              bit_tick_i,
  input  logic              tx_valid_i,
  input  logic [CHAR_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              tx_serial_o,
  input  logic              rx_serial_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [CHAR_W-1:0] rx_data_o,
  output logic              rx_perr_o
);
  mode_t mode;
  assign mode = mode_t'(mode_i);

  framer_tx #(.CHAR_W(CHAR_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (bit_tick_i),
    .mode_i     (mode),
    .in_valid_i (tx_valid_i),
    .in_data_i  (tx_data_i),
    .in_ready_o (tx_ready_o),
    .serial_o   (tx_serial_o)
  );

  framer_rx #(.CHAR_W(CHAR_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (bit_tick_i),
    .mode_i      (mode),
    .serial_i    (rx_serial_i),
    .out_valid_o (rx_valid_o),
    .out_ready_i (rx_ready_i),
    .out_data_o  (rx_data_o),
    .out_perr_o  (rx_perr_o)
  );

  a_r6_ready_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o && !bit_tick_i) |=> !tx_ready_o);

endmodule

// File: tb/test_char_framer.sv
module test_char_framer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] mode_i;
  logic       bit_tick;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready_o, tx_serial_o;
  logic       rx_valid_o, rx_perr_o;
  logic [7:0] rx_data_o;
  logic       rx_ready;
  logic       rx_drv, loop_en, rx_chk, done;
  logic       rx_line;

  int n_chk = 0;
  int n_bad = 0;
  bit         exp_bits[$];
  logic [8:0] rx_exp[$];
  logic [7:0] q_bytes[$];
  string      tx_tag = "R1";
  string      rx_tag = "R2";

  always #5 clk = ~clk;

  assign rx_line = loop_en ? tx_serial_o : rx_drv;

  char_framer i_char_framer (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bit_tick_i(bit_tick),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready_o),
    .tx_serial_o(tx_serial_o), .rx_serial_i(rx_line), .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready), .rx_data_o(rx_data_o), .rx_perr_o(rx_perr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    bit e;
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    if (exp_bits.size() > 0) begin
      e = exp_bits.pop_front();
      chk(tx_serial_o === e, tx_tag, 32'(tx_serial_o), 32'(e));
    end
  endtask

  task automatic push_frame(input logic [7:0] m, input logic [7:0] b);
    int nd;
    int ns;
    if (!m[5]) begin
      for (int i = 0; i < 8; i++) exp_bits.push_back(b[i]);
    end else begin
      exp_bits.push_back(1'b0);
      nd = m[0] ? 7 : 8;
      for (int i = 0; i < nd; i++) exp_bits.push_back(b[i]);
      if (m[2]) exp_bits.push_back((^(b & (m[0] ? 8'h7F : 8'hFF))) ^ m[1]);
      ns = (m[4:3] == 2'b00) ? 0 : ((m[4:3] == 2'b11) ? 2 : 1);
      for (int i = 0; i < ns; i++) exp_bits.push_back(1'b1);
    end
  endtask

  // driver: hands one byte over and queues its expected bits and character
  task automatic put(input logic [7:0] b);
    tx_valid = 1'b1;
    tx_data  = b;
    push_frame(mode_i, b);
    if (loop_en && rx_chk)
      rx_exp.push_back({1'b0, (mode_i[5] && mode_i[0]) ? (b & 8'h7F) : b});
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_bits.size() > 0) tick();
    for (int i = 0; i < 3; i++) exp_bits.push_back(1'b1);
    for (int i = 0; i < 3; i++) tick();
  endtask

  task automatic run_bytes(input logic [7:0] m);
    mode_i = m;
    put(q_bytes.pop_front());
    while (q_bytes.size() > 0 || exp_bits.size() > 0) begin
      if (q_bytes.size() > 0 && tx_ready_o) put(q_bytes.pop_front());
      tick();
    end
    drain();
  endtask

  task automatic settle(input logic [7:0] m);
    rx_chk  = 1'b0;
    loop_en = 1'b0;
    rx_drv  = 1'b1;
    mode_i  = m;
    for (int i = 0; i < 20; i++) tick();
    repeat (2) @(negedge clk);
    rx_chk = 1'b1;
  endtask

  task automatic drv_bit(input logic b);
    rx_drv = b;
    tick();
  endtask

  // monitor: pops the scoreboard on every accepted received byte
  always @(negedge clk) begin
    logic [8:0] e;
    if (rx_chk && rx_valid_o && rx_ready) begin
      if (rx_exp.size() == 0) begin
        chk(1'b0, rx_tag, 32'({rx_perr_o, rx_data_o}), 32'h1FF);
      end else begin
        e = rx_exp.pop_front();
        chk({rx_perr_o, rx_data_o} === e, rx_tag, 32'({rx_perr_o, rx_data_o}), 32'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic v;
    done = 1'b0; rst_n = 1'b0; mode_i = 8'h00; bit_tick = 1'b0;
    tx_valid = 1'b0; tx_data = 8'h00; rx_ready = 1'b1; rx_drv = 1'b1;
    loop_en = 1'b0; rx_chk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: reset state
    chk(tx_serial_o === 1'b1, "R6 reset line", 32'(tx_serial_o), 1);
    chk(tx_ready_o === 1'b1, "R6 reset ready", 32'(tx_ready_o), 1);
    chk(rx_valid_o === 1'b0, "R7 reset valid", 32'(rx_valid_o), 0);

    // R2: synchronous receive grouping, counted from reset
    rx_chk = 1'b1; rx_tag = "R2";
    foreach (q_bytes[i]) q_bytes.delete(i);
    rx_exp.push_back({1'b0, 8'hA5}); rx_exp.push_back({1'b0, 8'h3C}); rx_exp.push_back({1'b0, 8'h81});
    begin
      logic [7:0] pat [3];
      pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h81;
      for (int k = 0; k < 3; k++)
        for (int i = 0; i < 8; i++) drv_bit(pat[k][i]);
    end
    repeat (2) @(negedge clk);

    // R1: synchronous transmit, back to back
    rx_chk = 1'b0; tx_tag = "R1";
    q_bytes.push_back(8'hA5); q_bytes.push_back(8'h3C);
    q_bytes.push_back(8'hFF); q_bytes.push_back(8'h00);
    run_bytes(8'h00);

    // R3/R4/R6: 8 data, no parity, 1 stop, in loopback
    settle(8'h28);
    loop_en = 1'b1; tx_tag = "R3"; rx_tag = "R4";
    put(8'h55);
    chk(tx_ready_o === 1'b0, "R6 ready low after take", 32'(tx_ready_o), 0);
    q_bytes.push_back(8'h80); q_bytes.push_back(8'h01);
    while (q_bytes.size() > 0 || exp_bits.size() > 0) begin
      if (q_bytes.size() > 0 && tx_ready_o) put(q_bytes.pop_front());
      tick();
    end
    drain();

    // R3/R4: 7 data, even parity, 2 stop (bit 7 dropped)
    q_bytes.push_back(8'hC3); q_bytes.push_back(8'h2A);
    run_bytes(8'h3D);

    // R5: 8 data, odd parity, zero stop bits -> back-to-back start bits
    tx_tag = "R3"; rx_tag = "R5";
    q_bytes.push_back(8'h00); q_bytes.push_back(8'hFF); q_bytes.push_back(8'h96);
    run_bytes(8'h26);

    // R3: stop code 10 gives one stop bit, 7 data, no parity
    rx_tag = "R4";
    q_bytes.push_back(8'h7F); q_bytes.push_back(8'h00);
    run_bytes(8'h31);

    // R9: reserved bits set, same result as 8N1
    tx_tag = "R9"; rx_tag = "R9";
    q_bytes.push_back(8'h5A);
    run_bytes(8'hE8);

    // R8: mode change mid-character; R10: line still between strobes
    tx_tag = "R8"; rx_tag = "R8";
    mode_i = 8'h28;
    put(8'h0F);
    for (int i = 0; i < 3; i++) tick();
    mode_i = 8'h3D;
    v = tx_serial_o;
    repeat (5) @(negedge clk);
    chk(tx_serial_o === v, "R10 line held between strobes", 32'(tx_serial_o), 32'(v));
    put(8'hC3);
    drain();

    // R7: back-pressure on the receive side
    rx_chk = 1'b0; rx_ready = 1'b0; mode_i = 8'h28;
    put(8'h11);
    drain();
    repeat (5) @(negedge clk);
    chk(rx_valid_o === 1'b1, "R7 valid held", 32'(rx_valid_o), 1);
    chk(rx_data_o === 8'h11, "R7 data held", 32'(rx_data_o), 32'h11);
    put(8'h22);
    drain();
    chk(rx_data_o === 8'h22, "R7 overwrite", 32'(rx_data_o), 32'h22);
    rx_ready = 1'b1;
    @(negedge clk);
    chk(rx_valid_o === 1'b0, "R7 accepted", 32'(rx_valid_o), 0);

    // R4: parity fault then clean character, driven directly (8 data, odd)
    loop_en = 1'b0; rx_chk = 1'b1; rx_tag = "R4"; mode_i = 8'h26; rx_drv = 1'b1;
    tick();
    rx_exp.push_back({1'b1, 8'h12});
    rx_exp.push_back({1'b0, 8'h12});
    drv_bit(1'b0);
    for (int i = 0; i < 8; i++) drv_bit(1'(8'h12 >> i));
    drv_bit(1'b0);
    drv_bit(1'b0);
    for (int i = 0; i < 8; i++) drv_bit(1'(8'h12 >> i));
    drv_bit(1'b1);
    drv_bit(1'b1);

    repeat (5) @(negedge clk);
    chk(rx_exp.size() == 0, "R4 scoreboard drained", 32'(rx_exp.size()), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule